// File: doc/BRIEF.md
# Rename Map with Move Folding

This block is the register rename table of a small out-of-order core. It maps sixteen architectural registers onto physical register tags and renames one instruction per cycle. Each table entry pairs a physical tag with a signed offset. A register-to-register move or an add of an immediate is completed inside the table. The destination takes the source's tag, and the immediate is accumulated into the entry's offset, so such an instruction never needs an execution port. Every other instruction receives a fresh tag from a counter allocator, and its entry offset is cleared.

The table holds only register numbers, tags and offsets, never operand data. A source lookup returns a tag and an offset. The consumer adds that offset to the physical register value before use. The flags are a renamed resource with a producer tag of their own. A conditional move is never folded, because its result depends on the flags at run time. It reports two data sources plus the flags tag.

Before each rename, the whole table and the flags tag are saved into a ring of checkpoint slots. A restore request names a slot and reloads that snapshot in a single cycle. This returns the mapping to the point before the instruction that used the slot, for use on a flush or an interrupt.

Top module: `renameMap`

## Requirements
- R1: After reset, register i maps to tag i with offset 0, the flags tag equals NUM_ARCH, the first tag handed out is NUM_ARCH+1, and ckSlot is 0.
- R2: Source lookups are combinational from the current table and give the mapping from before the instruction presented in the same cycle, even when a source equals the destination.
- R3: A rename with inOp=1 (move) sets the destination entry to the tag and offset of srcA, raises folded, and consumes no tag.
- R4: A rename with inOp=2 (add immediate) sets the destination tag to the tag of srcA and its offset to the srcA offset plus inImm, in 16-bit two's complement arithmetic that wraps.
- R5: A rename with inOp=0 (plain ALU) or inOp=3 (conditional move) gives the destination the next allocator tag and offset 0, with folded low.
- R6: The allocator advances only on non-folded renames. It steps by one and wraps from 2^TAG_W-1 back to NUM_ARCH+1.
- R7: A non-folded rename with inWrFlags high makes its new tag the flags tag. A folded rename leaves the flags tag unchanged whatever inWrFlags is.
- R8: usesFlags is high exactly when inValid is high and inOp=3. Such an instruction is never folded.
- R9: Each rename stores the pre-instruction table and flags tag in slot ckSlot. ckSlot then advances by one, modulo CK_DEPTH.
- R10: restoreValid reloads the table and flags tag from slot restoreSlot in one cycle and sets ckSlot to restoreSlot. A rename presented in the same cycle is discarded, and the allocator is not rewound.
- R11: With inValid and restoreValid both low, no table entry, flags tag, allocator or ckSlot changes.
- R12: Register 0 is an ordinary entry that can be written by folds and allocations alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An instruction is presented for renaming |
| inOp | input | 2 | 0 ALU, 1 move, 2 add immediate, 3 conditional move |
| inDst | input | AREG_W | Destination architectural register |
| inSrcA | input | AREG_W | First source register |
| inSrcB | input | AREG_W | Second source register |
| inImm | input | OFS_W | Immediate for the add-immediate fold |
| inWrFlags | input | 1 | Instruction produces the flags |
| restoreValid | input | 1 | Reload the table from a checkpoint |
| restoreSlot | input | SLOT_W | Checkpoint slot to reload |
| srcATag | output | TAG_W | Physical tag of srcA |
| srcAOfs | output | OFS_W | Offset of srcA |
| srcBTag | output | TAG_W | Physical tag of srcB |
| srcBOfs | output | OFS_W | Offset of srcB |
| flagTag | output | TAG_W | Current producer tag of the flags |
| usesFlags | output | 1 | Instruction reads the flags as a third source |
| dstTag | output | TAG_W | Tag given to the destination |
| dstOfs | output | OFS_W | Offset given to the destination |
| folded | output | 1 | Instruction completed in the table |
| ckSlot | output | SLOT_W | Slot receiving this instruction's checkpoint |

## Verification
The bench builds the block with TAG_W=5 and CK_DEPTH=4, keeping sixteen registers and 16-bit offsets. That leaves only fifteen allocatable tags, so the allocator wraps many times within a short run, and the four-slot ring wraps every four renames. An exhaustive sweep of all 256 move pairs, plus long random mixes with restores, therefore reaches every wrap boundary and every slot. The offset overflow cases are driven with chosen immediates near the signed limits.

// File: rtl/renameMapPkg.sv
package renameMapPkg;

  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_MOV  = 2'd1,
    OP_ADDI = 2'd2,
    OP_CMOV = 2'd3
  } renOp_e;

  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic doRename;
    logic doFold;
    logic addImm;
    logic wrFlags;
    logic doRestore;
  } mapStrobe_t;

endpackage

// File: rtl/renameCtrl.sv
module renameCtrl
  import renameMapPkg::*;
(
  input  logic       inValid,
  input  logic [1:0] inOp,
  input  logic       inWrFlags,
  input  logic       restoreValid,
  output mapStrobe_t strobe,
  output logic       usesFlags
);

  renOp_e opCode;
  logic   foldable;

  assign opCode   = renOp_e'(inOp);
  assign foldable = (opCode == OP_MOV) || (opCode == OP_ADDI);

  always_comb begin
    strobe.doRestore = restoreValid;
    // A restore wins over a rename in the same cycle.
    strobe.doRename  = inValid && !restoreValid;
    strobe.doFold    = strobe.doRename && foldable;
    strobe.addImm    = strobe.doRename && (opCode == OP_ADDI);
    strobe.wrFlags   = strobe.doRename && !foldable && inWrFlags;
  end

  assign usesFlags = inValid && (opCode == OP_CMOV);

endmodule

// File: rtl/renameData.sv
module renameData
  import renameMapPkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int TAG_W    = 7,
  parameter int OFS_W    = 16,
  parameter int CK_DEPTH = 8,
  localparam int AREG_W  = $clog2(NUM_ARCH),
  localparam int SLOT_W  = $clog2(CK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic [AREG_W-1:0] inDst,
  input  logic [AREG_W-1:0] inSrcA,
  input  logic [AREG_W-1:0] inSrcB,
  input  logic [OFS_W-1:0]  inImm,
  input  logic [SLOT_W-1:0] restoreSlot,
  output logic [TAG_W-1:0]  srcATag,
  output logic [OFS_W-1:0]  srcAOfs,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [OFS_W-1:0]  srcBOfs,
  output logic [TAG_W-1:0]  flagTag,
  output logic [TAG_W-1:0]  dstTag,
  output logic [OFS_W-1:0]  dstOfs,
  output logic [SLOT_W-1:0] ckSlot
);

  localparam int FIRST_FREE = NUM_ARCH + 1;
  localparam int LAST_TAG   = (1 << TAG_W) - 1;

  wire [NUM_ARCH-1:0][TAG_W-1:0]               mapTag;
  wire [NUM_ARCH-1:0][OFS_W-1:0]               mapOfs;
  wire [CK_DEPTH-1:0][NUM_ARCH-1:0][TAG_W-1:0] ckTag;
  wire [CK_DEPTH-1:0][NUM_ARCH-1:0][OFS_W-1:0] ckOfs;
  wire [CK_DEPTH-1:0][TAG_W-1:0]               ckFlag;

  logic [TAG_W-1:0]  flagReg;
  logic [TAG_W-1:0]  allocReg;
  logic [TAG_W-1:0]  allocNext;
  logic [SLOT_W-1:0] ckPtr;
  logic [SLOT_W-1:0] ckPtrNext;

  // Lookups read the table as it stands before this cycle's write.
  assign srcATag = mapTag[inSrcA];
  assign srcAOfs = mapOfs[inSrcA];
  assign srcBTag = mapTag[inSrcB];
  assign srcBOfs = mapOfs[inSrcB];
  assign flagTag = flagReg;
  assign ckSlot  = ckPtr;

  assign dstTag = strobe.doFold ? srcATag : allocReg;
  assign dstOfs = strobe.doFold ? (srcAOfs + (strobe.addImm ? inImm : '0)) : '0;

  assign allocNext = (allocReg == TAG_W'(LAST_TAG)) ? TAG_W'(FIRST_FREE) : allocReg + 1'b1;
  assign ckPtrNext = (ckPtr == SLOT_W'(CK_DEPTH - 1)) ? '0 : ckPtr + 1'b1;

  // One register pair per architectural entry.
  for (genvar e = 0; e < NUM_ARCH; e++) begin : gEntry
    logic [TAG_W-1:0] entTag;
    logic [OFS_W-1:0] entOfs;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entTag <= TAG_W'(e);
        entOfs <= '0;
      end else if (strobe.doRestore) begin
        entTag <= ckTag[restoreSlot][e];
        entOfs <= ckOfs[restoreSlot][e];
      end else if (strobe.doRename && (inDst == AREG_W'(e))) begin
        entTag <= dstTag;
        entOfs <= dstOfs;
      end
    end
    assign mapTag[e] = entTag;
    assign mapOfs[e] = entOfs;
  end

  // Checkpoint ring: the slot under ckPtr captures the pre-rename table.
  for (genvar s = 0; s < CK_DEPTH; s++) begin : gSlot
    logic [NUM_ARCH-1:0][TAG_W-1:0] slotTag;
    logic [NUM_ARCH-1:0][OFS_W-1:0] slotOfs;
    logic [TAG_W-1:0]               slotFlag;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_ARCH; i++) begin
          slotTag[i] <= TAG_W'(i);
          slotOfs[i] <= '0;
        end
        slotFlag <= TAG_W'(NUM_ARCH);
      end else if (strobe.doRename && (ckPtr == SLOT_W'(s))) begin
        slotTag  <= mapTag;
        slotOfs  <= mapOfs;
        slotFlag <= flagReg;
      end
    end
    assign ckTag[s]  = slotTag;
    assign ckOfs[s]  = slotOfs;
    assign ckFlag[s] = slotFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg  <= TAG_W'(NUM_ARCH);
      allocReg <= TAG_W'(FIRST_FREE);
      ckPtr    <= '0;
    end else if (strobe.doRestore) begin
      flagReg <= ckFlag[restoreSlot];
      ckPtr   <= restoreSlot;
    end else if (strobe.doRename) begin
      ckPtr <= ckPtrNext;
      if (!strobe.doFold) allocReg <= allocNext;
      if (strobe.wrFlags) flagReg <= allocReg;
    end
  end

endmodule

// File: rtl/renameMap.sv
module renameMap
  import renameMapPkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int TAG_W    = 7,
  parameter int OFS_W    = 16,
  parameter int CK_DEPTH = 8,
  localparam int AREG_W  = $clog2(NUM_ARCH),
  localparam int SLOT_W  = $clog2(CK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [AREG_W-1:0] inDst,
  input  logic [AREG_W-1:0] inSrcA,
  input  logic [AREG_W-1:0] inSrcB,
  input  logic [OFS_W-1:0]  inImm,
  input  logic              inWrFlags,
  input  logic              restoreValid,
  input  logic [SLOT_W-1:0] restoreSlot,
  output logic [TAG_W-1:0]  srcATag,
  output logic [OFS_W-1:0]  srcAOfs,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [OFS_W-1:0]  srcBOfs,
  output logic [TAG_W-1:0]  flagTag,
  output logic              usesFlags,
  output logic [TAG_W-1:0]  dstTag,
  output logic [OFS_W-1:0]  dstOfs,
  output logic              folded,
  output logic [SLOT_W-1:0] ckSlot
);

  mapStrobe_t strobe;

  renameCtrl uCtrl (
    .inValid      (inValid),
    .inOp         (inOp),
    .inWrFlags    (inWrFlags),
    .restoreValid (restoreValid),
    .strobe       (strobe),
    .usesFlags    (usesFlags)
  );

  renameData #(
    .NUM_ARCH (NUM_ARCH),
    .TAG_W    (TAG_W),
    .OFS_W    (OFS_W),
    .CK_DEPTH (CK_DEPTH)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inDst       (inDst),
    .inSrcA      (inSrcA),
    .inSrcB      (inSrcB),
    .inImm       (inImm),
    .restoreSlot (restoreSlot),
    .srcATag     (srcATag),
    .srcAOfs     (srcAOfs),
    .srcBTag     (srcBTag),
    .srcBOfs     (srcBOfs),
    .flagTag     (flagTag),
    .dstTag      (dstTag),
    .dstOfs      (dstOfs),
    .ckSlot      (ckSlot)
  );

  assign folded = strobe.doFold;

endmodule

// File: rtl/renameMapChk.sv
module renameMapChk #(
  parameter int NUM_ARCH = 16,
  parameter int TAG_W    = 7,
  parameter int OFS_W    = 16,
  parameter int CK_DEPTH = 8,
  localparam int AREG_W  = $clog2(NUM_ARCH),
  localparam int SLOT_W  = $clog2(CK_DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        inOp,
  input logic [AREG_W-1:0] inDst,
  input logic [AREG_W-1:0] inSrcA,
  input logic [OFS_W-1:0]  inImm,
  input logic              inWrFlags,
  input logic              restoreValid,
  input logic [SLOT_W-1:0] restoreSlot,
  input logic [TAG_W-1:0]  srcATag,
  input logic [OFS_W-1:0]  srcAOfs,
  input logic [TAG_W-1:0]  dstTag,
  input logic              folded,
  input logic              usesFlags,
  input logic [TAG_W-1:0]  flagTag,
  input logic [SLOT_W-1:0] ckSlot
);

  logic renNow;
  assign renNow = inValid && !restoreValid;

  p_fold_tag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (renNow && folded) |=>
      (restoreValid || inSrcA != $past(inDst) || srcATag == $past(srcATag)));

  p_addi_ofs_r4: assert property (@(posedge clk) disable iff (!rstN)
    (renNow && inOp == 2'd2) |=>
      (restoreValid || inSrcA != $past(inDst) ||
       srcAOfs == OFS_W'($past(srcAOfs) + $past(inImm))));

  p_alloc_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (renNow && !folded) |=>
      (restoreValid || inSrcA != $past(inDst) ||
       (srcATag == $past(dstTag) && srcAOfs == '0)));

  p_alloc_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !folded) |-> (int'(dstTag) >= NUM_ARCH + 1));

  p_flag_owner_r7: assert property (@(posedge clk) disable iff (!rstN)
    (renNow && !folded && inWrFlags) |=> (flagTag == $past(dstTag)));

  p_cmov_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'd3) |-> (!folded && usesFlags));

  p_slot_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    renNow |=> (ckSlot == SLOT_W'((int'($past(ckSlot)) + 1) % CK_DEPTH)));

  p_restore_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |=> (ckSlot == $past(restoreSlot)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !restoreValid) |=> ($stable(ckSlot) && $stable(flagTag)));

endmodule

bind renameMap renameMapChk #(
  .NUM_ARCH (NUM_ARCH),
  .TAG_W    (TAG_W),
  .OFS_W    (OFS_W),
  .CK_DEPTH (CK_DEPTH)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inOp         (inOp),
  .inDst        (inDst),
  .inSrcA       (inSrcA),
  .inImm        (inImm),
  .inWrFlags    (inWrFlags),
  .restoreValid (restoreValid),
  .restoreSlot  (restoreSlot),
  .srcATag      (srcATag),
  .srcAOfs      (srcAOfs),
  .dstTag       (dstTag),
  .folded       (folded),
  .usesFlags    (usesFlags),
  .flagTag      (flagTag),
  .ckSlot       (ckSlot)
);

// File: tb/test_renameMap.sv
module test_renameMap;

  localparam int CLK_PERIOD = 10;
  localparam int NA  = 16;
  localparam int TW  = 5;
  localparam int OW  = 16;
  localparam int CKD = 4;
  localparam int AW  = 4;
  localparam int SW  = 2;
  localparam int FIRST = NA + 1;
  localparam int LAST  = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [1:0]    inOp = '0;
  logic [AW-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic [OW-1:0] inImm = '0;
  logic          inWrFlags = 1'b0;
  logic          restoreValid = 1'b0;
  logic [SW-1:0] restoreSlot = '0;
  logic [TW-1:0] srcATag, srcBTag, flagTag, dstTag;
  logic [OW-1:0] srcAOfs, srcBOfs, dstOfs;
  logic          usesFlags, folded;
  logic [SW-1:0] ckSlot;

  int nChecks = 0;
  int nFails  = 0;

  // Reference model of the requirements.
  int          mTag [NA];
  logic [OW-1:0] mOfs [NA];
  int          mFlag, mAlloc, mPtr;
  int          ckT [CKD][NA];
  logic [OW-1:0] ckO [CKD][NA];
  int          ckF [CKD];

  always #(CLK_PERIOD/2) clk = ~clk;

  renameMap #(.NUM_ARCH(NA), .TAG_W(TW), .OFS_W(OW), .CK_DEPTH(CKD)) i_renameMap (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inDst(inDst),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inImm(inImm), .inWrFlags(inWrFlags),
    .restoreValid(restoreValid), .restoreSlot(restoreSlot),
    .srcATag(srcATag), .srcAOfs(srcAOfs), .srcBTag(srcBTag), .srcBOfs(srcBOfs),
    .flagTag(flagTag), .usesFlags(usesFlags), .dstTag(dstTag), .dstOfs(dstOfs),
    .folded(folded), .ckSlot(ckSlot)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NA; i++) begin
      mTag[i] = i;
      mOfs[i] = '0;
    end
    mFlag = NA; mAlloc = FIRST; mPtr = 0;
    for (int s = 0; s < CKD; s++) begin
      for (int i = 0; i < NA; i++) begin
        ckT[s][i] = i;
        ckO[s][i] = '0;
      end
      ckF[s] = NA;
    end
  endtask

  // Present one cycle of inputs, check outputs mid-cycle, then update the model.
  task automatic step(input logic v, input int op, input int dst, input int a,
                      input int b, input logic [OW-1:0] imm, input logic wf,
                      input logic rv, input int rs, input string lkReq,
                      input string dstReq);
    logic isFold;
    int eTag;
    logic [OW-1:0] eOfs;
    @(negedge clk);
    inValid = v; inOp = 2'(op); inDst = AW'(dst); inSrcA = AW'(a); inSrcB = AW'(b);
    inImm = imm; inWrFlags = wf; restoreValid = rv; restoreSlot = SW'(rs);
    #1;
    isFold = v && !rv && (op == 1 || op == 2);
    chk(int'(srcATag) == mTag[a], lkReq, "srcATag", int'(srcATag), mTag[a]);
    chk(srcAOfs == mOfs[a], lkReq, "srcAOfs", int'(srcAOfs), int'(mOfs[a]));
    chk(int'(srcBTag) == mTag[b], lkReq, "srcBTag", int'(srcBTag), mTag[b]);
    chk(srcBOfs == mOfs[b], lkReq, "srcBOfs", int'(srcBOfs), int'(mOfs[b]));
    chk(int'(flagTag) == mFlag, "R7", "flagTag", int'(flagTag), mFlag);
    chk(int'(ckSlot) == mPtr, "R9", "ckSlot", int'(ckSlot), mPtr);
    chk(usesFlags == (v && op == 3), "R8", "usesFlags", int'(usesFlags), int'(v && op == 3));
    chk(folded == isFold, dstReq, "folded", int'(folded), int'(isFold));
    eTag = isFold ? mTag[a] : mAlloc;
    eOfs = isFold ? ((op == 2) ? mOfs[a] + imm : mOfs[a]) : '0;
    if (v && !rv) begin
      chk(int'(dstTag) == eTag, dstReq, "dstTag", int'(dstTag), eTag);
      chk(dstOfs == eOfs, dstReq, "dstOfs", int'(dstOfs), int'(eOfs));
    end
    @(posedge clk);
    if (rv) begin
      for (int i = 0; i < NA; i++) begin
        mTag[i] = ckT[rs][i];
        mOfs[i] = ckO[rs][i];
      end
      mFlag = ckF[rs];
      mPtr = rs;
    end else if (v) begin
      for (int i = 0; i < NA; i++) begin
        ckT[mPtr][i] = mTag[i];
        ckO[mPtr][i] = mOfs[i];
      end
      ckF[mPtr] = mFlag;
      mPtr = (mPtr + 1) % CKD;
      mTag[dst] = eTag;
      mOfs[dst] = eOfs;
      if (!isFold) begin
        if (wf) mFlag = mAlloc;
        mAlloc = (mAlloc == LAST) ? FIRST : mAlloc + 1;
      end
    end
  endtask

  task automatic sweepLookups(input string req);
    for (int i = 0; i < NA; i++)
      step(1'b0, 0, 0, i, NA - 1 - i, '0, 1'b0, 1'b0, 0, req, req);
  endtask

  initial begin
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1: reset mapping, flags tag and slot.
    sweepLookups("R1");
    // R5: first allocation is NUM_ARCH+1.
    step(1'b1, 0, 5, 5, 6, '0, 1'b0, 1'b0, 0, "R2", "R5");

    // R4: give every register a distinct offset, src==dst reads old mapping (R2).
    for (int i = 0; i < NA; i++)
      step(1'b1, 2, i, i, 0, OW'(i * 1111 + 7), 1'b0, 1'b0, 0, "R2", "R4");

    // R3, R12: exhaustive move sweep over all pairs including r0.
    for (int d = 0; d < NA; d++)
      for (int s = 0; s < NA; s++)
        step(1'b1, 1, d, s, (d + s) % NA, '0, 1'b1, 1'b0, 0, "R12",
             (d == 0) ? "R12" : "R3");

    // R4: offset wrap at the signed limits.
    step(1'b1, 0, 3, 0, 0, '0, 1'b0, 1'b0, 0, "R2", "R5");
    step(1'b1, 2, 3, 3, 1, 16'h7FFF, 1'b0, 1'b0, 0, "R2", "R4");
    step(1'b1, 2, 3, 3, 1, 16'h0001, 1'b0, 1'b0, 0, "R2", "R4");
    step(1'b1, 2, 4, 3, 1, 16'hFFFF, 1'b0, 1'b0, 0, "R2", "R4");
    step(1'b1, 2, 4, 4, 3, 16'h8000, 1'b0, 1'b0, 0, "R4", "R4");

    // R6, R7: allocator wrap with alternating flag writes.
    for (int k = 0; k < 40; k++)
      step(1'b1, (k % 3 == 0) ? 3 : 0, k % NA, (k + 1) % NA, (k + 2) % NA, '0,
           1'(k % 2), 1'b0, 0, "R2", "R6");

    // R7: folds with inWrFlags high keep the flags tag.
    step(1'b1, 1, 7, 8, 9, '0, 1'b1, 1'b0, 0, "R7", "R7");
    step(1'b1, 2, 8, 7, 9, 16'h0010, 1'b1, 1'b0, 0, "R7", "R7");
    // R8: conditional move allocates and reports flags.
    step(1'b1, 3, 9, 7, 8, 16'h1234, 1'b1, 1'b0, 0, "R8", "R8");

    // R11: idle cycles with busy inputs change nothing.
    for (int k = 0; k < 6; k++)
      step(1'b0, k % 4, k, k + 1, k + 2, 16'hBEEF, 1'b1, 1'b0, 0, "R11", "R11");
    sweepLookups("R11");

    // R10: restore each slot, with a rename in the same cycle discarded.
    for (int s = 0; s < CKD; s++) begin
      for (int k = 0; k < 5; k++)
        step(1'b1, k % 4, (s + k) % NA, k, s, OW'(k * 3 + 1), 1'b1, 1'b0, 0, "R2", "R9");
      step(1'b1, 0, 1, 2, 3, '0, 1'b1, 1'b1, s, "R10", "R10");
      sweepLookups("R10");
      step(1'b1, 0, 2, 1, 2, '0, 1'b0, 1'b0, 0, "R10", "R10");
    end

    // Random mix of every operation and restores.
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 90, int'($urandom_range(0, 3)), int'($urandom_range(0, NA - 1)),
           int'($urandom_range(0, NA - 1)), int'($urandom_range(0, NA - 1)),
           OW'($urandom), 1'($urandom), r >= 95, int'($urandom_range(0, CKD - 1)),
           "R2", "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule